// File: doc/BRIEF.md
# Shadow Register Update Controller

This block keeps a bank of master configuration registers and a matching bank of shadow registers, and decides when each shadow register copies its master. Software writes the masters through a simple indexed write port. The rest of the chip reads the shadow values, so a whole group of settings can change together on one chosen event, not one at a time as each write arrives.

A shadow register can be refreshed in two ways. In immediate mode, a master write is copied into its own shadow a fixed number of clocks later, and the per-register mask plays no part. Otherwise a trigger event copies every shadow whose mask bit is set. There are four kinds of trigger event: a software update strobe, a rising edge on one selected external update line, a rising edge on one selected external transmit-enable line, and an internal transmit-enable pulse. The block raises that internal pulse itself after a software or external-update trigger. The external lines are synchronised inside the block and are gated by a master strobe enable.

Top module: `shadow_update_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, every shadow and master register takes the reset value 0xA5C3, `int_tx_o` goes to 0, and any immediate copies that are still in flight are dropped.
- R2: With `imm_mode` high, a write to register i at edge k makes shadow i show the master value at edge k+4. Shadow i is unchanged through edge k+3, whatever `upd_mask` holds.
- R3: A trigger event copies master i into shadow i only when `upd_mask` bit i is 1. Bit i belongs to register i. Shadows with a 0 mask bit hold their value.
- R4: When `sw_upd` is high at edge k, the masked copy happens at edge k+1. The request clears itself, so one cycle of `sw_upd` gives exactly one copy.
- R5: With `strobe_en` and `hw_upd_en` high, a rising level on `upd_in[upd_sel]` first sampled at edge k makes the masked copy at edge k+2. A line held high gives only one copy.
- R6: With `strobe_en` and `ext_tx_en` high, a rising level on `tx_in[tx_sel]` behaves with the same timing as in R5.
- R7: While `strobe_en` is low, `upd_in` and `tx_in` have no effect on the shadows.
- R8: A line of `upd_in` or `tx_in` that the matching select field does not name has no effect.
- R9: With `int_tx_en` high, a software copy or external-update copy at edge e drives `int_tx_o` high for the cycle after e, and causes one more masked copy at edge e+1.
- R10: A write with `wr_idx` of 10 or more changes no master register.
- R11: When a master write and a copy of that register fall on the same edge, the shadow takes the master value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Master register write strobe |
| wr_idx | input | 4 | Index of the master register to write |
| wr_data | input | 16 | Master write data |
| imm_mode | input | 1 | Immediate update mode enable |
| strobe_en | input | 1 | Master enable for external strobes |
| hw_upd_en | input | 1 | Enable for external update lines |
| ext_tx_en | input | 1 | Enable for external transmit-enable lines |
| int_tx_en | input | 1 | Enable for internal transmit-enable pulse |
| upd_sel | input | 2 | Selects one of the update lines |
| tx_sel | input | 2 | Selects one of the transmit-enable lines |
| upd_mask | input | 10 | Per-register participation in triggered copies |
| sw_upd | input | 1 | Software update request strobe |
| upd_in | input | 4 | Asynchronous external update lines |
| tx_in | input | 4 | Asynchronous external transmit-enable lines |
| slave_q | output | 160 | Shadow registers, register i at bits 16*i+15 down to 16*i |
| int_tx_o | output | 1 | Internal transmit-enable pulse |

## Verification
Two events can land on the same edge. One case is a master write together with a triggered or immediate copy of the same register. The other is an expiring immediate copy together with a masked trigger event. The random phase uses dense writes to few indices and frequent strobes, so both cases come up often. A directed case also lines up a software strobe with a write to the same register. A cycle-accurate bench model decides the outcome: it computes each shadow from the master value held before the edge, and the bench compares every shadow after every edge.

// File: rtl/usc_pkg.sv
package usc_pkg;
  typedef struct packed {
    logic imm_mode;
    logic strobe_en;
    logic hw_upd_en;
    logic ext_tx_en;
    logic int_tx_en;
  } usc_cfg_t;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_DYN  = 2'd1,
    SRC_TX   = 2'd2,
    SRC_INT  = 2'd3
  } usc_src_e;
endpackage

// File: rtl/usc_edge_sync.sv
module usc_edge_sync #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  localparam int NST = SYNC + 1;
  logic [NST-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= '0;
    else     stg <= {stg[NST-2:0], din};
  end

  assign rise = stg[SYNC-1] & ~stg[SYNC];

  // R5 / R6: one assertion of a line yields a single-cycle event
  p_single_rise_r5: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/usc_imm_delay.sv
module usc_imm_delay #(
  parameter int DEPTH = 4,
  parameter int IW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  logic [IW-1:0] in_idx,
  output logic          out_vld,
  output logic [IW-1:0] out_idx
);
  logic [DEPTH-1:0]         vld;
  logic [DEPTH-1:0][IW-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld[0] <= 1'b0;
      idx[0] <= '0;
    end else begin
      vld[0] <= in_vld;
      idx[0] <= in_idx;
    end
  end

  for (genvar s = 1; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        vld[s] <= 1'b0;
        idx[s] <= '0;
      end else begin
        vld[s] <= vld[s-1];
        idx[s] <= idx[s-1];
      end
    end
  end

  assign out_vld = vld[DEPTH-1];
  assign out_idx = idx[DEPTH-1];

  if (DEPTH > 1) begin : g_chk
    // R2: an expiring copy was one stage earlier in the previous cycle
    p_imm_lag_r2: assert property (@(posedge clk) disable iff (rst)
      out_vld |-> $past(vld[DEPTH-2]));
  end
endmodule

// File: rtl/usc_reg_bank.sv
module usc_reg_bank #(
  parameter int          NREG    = 10,
  parameter int          DW      = 16,
  parameter int          IW      = 4,
  parameter logic [15:0] RST_VAL = 16'hA5C3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [DW-1:0]     wr_data,
  input  logic [NREG-1:0]   copy_en,
  output logic [NREG*DW-1:0] slave_q
);
  logic [NREG-1:0][DW-1:0] mst;
  logic [NREG-1:0][DW-1:0] slv;
  logic                    idx_ok;

  assign idx_ok = ({1'b0, wr_idx} < (IW+1)'(NREG));

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        mst[i] <= DW'(RST_VAL);
        slv[i] <= DW'(RST_VAL);
      end else begin
        if (wr_en && wr_idx == IW'(i)) mst[i] <= wr_data;
        if (copy_en[i])                slv[i] <= mst[i];
      end
    end

    // R3: a shadow without a copy enable keeps its value
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
      !copy_en[i] |=> $stable(slv[i]));
  end

  assign slave_q = slv;

  // R10: writes outside the bank touch no master
  p_oob_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !idx_ok) |=> $stable(mst));
endmodule

// File: rtl/shadow_update_ctrl.sv
module shadow_update_ctrl #(
  parameter int          NREG    = 10,
  parameter int          DW      = 16,
  parameter int          NSTRB   = 4,
  parameter int          IMM_DLY = 4,
  parameter int          SYNC    = 2,
  parameter logic [15:0] RST_VAL = 16'hA5C3,
  localparam int         IW      = $clog2(NREG),
  localparam int         SELW    = $clog2(NSTRB)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IW-1:0]      wr_idx,
  input  logic [DW-1:0]      wr_data,
  input  logic               imm_mode,
  input  logic               strobe_en,
  input  logic               hw_upd_en,
  input  logic               ext_tx_en,
  input  logic               int_tx_en,
  input  logic [SELW-1:0]    upd_sel,
  input  logic [SELW-1:0]    tx_sel,
  input  logic [NREG-1:0]    upd_mask,
  input  logic               sw_upd,
  input  logic [NSTRB-1:0]   upd_in,
  input  logic [NSTRB-1:0]   tx_in,
  output logic [NREG*DW-1:0] slave_q,
  output logic               int_tx_o
);
  import usc_pkg::*;

  usc_cfg_t         cfg;
  usc_src_e         src;
  logic [NSTRB-1:0] upd_rise, tx_rise;
  logic             upd_fire, tx_fire, any_fire;
  logic             sw_bit, int_tx_q;
  logic             imm_vld;
  logic [IW-1:0]    imm_idx;
  logic [NREG-1:0]  copy_en;

  assign cfg = '{imm_mode: imm_mode, strobe_en: strobe_en, hw_upd_en: hw_upd_en,
                 ext_tx_en: ext_tx_en, int_tx_en: int_tx_en};

  for (genvar j = 0; j < NSTRB; j++) begin : g_line
    usc_edge_sync #(.SYNC(SYNC)) u_upd (
      .clk(clk), .rst(rst), .din(upd_in[j]), .rise(upd_rise[j]));
    usc_edge_sync #(.SYNC(SYNC)) u_tx (
      .clk(clk), .rst(rst), .din(tx_in[j]), .rise(tx_rise[j]));
  end

  assign upd_fire = cfg.strobe_en & cfg.hw_upd_en & upd_rise[upd_sel];
  assign tx_fire  = cfg.strobe_en & cfg.ext_tx_en & tx_rise[tx_sel];

  always_comb begin
    if (sw_bit || upd_fire) src = SRC_DYN;
    else if (tx_fire)       src = SRC_TX;
    else if (int_tx_q)      src = SRC_INT;
    else                    src = SRC_NONE;
  end
  assign any_fire = (src != SRC_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_bit   <= 1'b0;
      int_tx_q <= 1'b0;
    end else begin
      sw_bit   <= sw_upd;
      int_tx_q <= cfg.int_tx_en & (src == SRC_DYN);
    end
  end
  assign int_tx_o = int_tx_q;

  usc_imm_delay #(.DEPTH(IMM_DLY), .IW(IW)) u_dly (
    .clk(clk), .rst(rst),
    .in_vld(wr_en & cfg.imm_mode), .in_idx(wr_idx),
    .out_vld(imm_vld), .out_idx(imm_idx));

  for (genvar i = 0; i < NREG; i++) begin : g_en
    assign copy_en[i] = (any_fire & upd_mask[i]) | (imm_vld & (imm_idx == IW'(i)));
  end

  usc_reg_bank #(.NREG(NREG), .DW(DW), .IW(IW), .RST_VAL(RST_VAL)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .copy_en(copy_en), .slave_q(slave_q));

  // R4: the software request lasts one cycle unless re-requested
  p_sw_selfclr_r4: assert property (@(posedge clk) disable iff (rst)
    (sw_bit && !sw_upd) |=> !sw_bit);

  // R7: a shadow change with no software, internal or immediate cause needs strobe_en
  p_hw_needs_en_r7: assert property (@(posedge clk) disable iff (rst)
    (!$stable(slave_q) && !$past(rst) && !$past(sw_bit) && !$past(int_tx_q)
     && !$past(imm_vld)) |-> $past(strobe_en));

  // R9: the internal pulse follows a software request or an update-line event
  p_int_tx_src_r9: assert property (@(posedge clk) disable iff (rst)
    int_tx_o |-> ($past(sw_upd, 2) || $past(upd_fire)));
endmodule

// File: tb/sim_shadow_update_ctrl.sv
module sim_shadow_update_ctrl;
  localparam int CLK = 10;
  localparam int NR  = 10;
  localparam logic [15:0] RV = 16'hA5C3;

  logic clk = 0, rst = 1;
  logic wr_en = 0; logic [3:0] wr_idx = 0; logic [15:0] wr_data = 0;
  logic imm_mode = 0, strobe_en = 0, hw_upd_en = 0, ext_tx_en = 0, int_tx_en = 0;
  logic [1:0] upd_sel = 0, tx_sel = 0;
  logic [NR-1:0] upd_mask = 0;
  logic sw_upd = 0;
  logic [3:0] upd_in = 0, tx_in = 0;
  logic [NR*16-1:0] slave_q;
  logic int_tx_o;

  int n_chk = 0, n_bad = 0;
  string cur_req = "R1";
  logic started = 0;

  always #(CLK/2) clk = ~clk;

  shadow_update_ctrl u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .imm_mode(imm_mode), .strobe_en(strobe_en), .hw_upd_en(hw_upd_en),
    .ext_tx_en(ext_tx_en), .int_tx_en(int_tx_en), .upd_sel(upd_sel), .tx_sel(tx_sel),
    .upd_mask(upd_mask), .sw_upd(sw_upd), .upd_in(upd_in), .tx_in(tx_in),
    .slave_q(slave_q), .int_tx_o(int_tx_o));

  // reference model built from the requirements
  logic [15:0] m_mst [NR];
  logic [15:0] m_slv [NR];
  logic        m_pv  [4];
  logic [3:0]  m_pi  [4];
  logic        m_sw, m_itx;
  logic [3:0]  u1, u2, u3, t1, t2, t3;

  function automatic logic [NR*16-1:0] model_flat();
    logic [NR*16-1:0] f;
    for (int i = 0; i < NR; i++) f[i*16 +: 16] = m_slv[i];
    return f;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NR; i++) begin m_mst[i] = RV; m_slv[i] = RV; end
      for (int s = 0; s < 4; s++) begin m_pv[s] = 0; m_pi[s] = 0; end
      m_sw = 0; m_itx = 0;
      u1 = 0; u2 = 0; u3 = 0; t1 = 0; t2 = 0; t3 = 0;
    end else begin
      logic fu, ft, any;
      fu  = strobe_en & hw_upd_en & u2[upd_sel] & ~u3[upd_sel];
      ft  = strobe_en & ext_tx_en & t2[tx_sel] & ~t3[tx_sel];
      any = fu | ft | m_sw | m_itx;
      for (int i = 0; i < NR; i++)
        if ((any && upd_mask[i]) || (m_pv[3] && m_pi[3] == 4'(i))) m_slv[i] = m_mst[i];
      m_itx = int_tx_en & (m_sw | fu);
      m_sw  = sw_upd;
      for (int s = 3; s > 0; s--) begin m_pv[s] = m_pv[s-1]; m_pi[s] = m_pi[s-1]; end
      m_pv[0] = wr_en & imm_mode; m_pi[0] = wr_idx;
      if (wr_en && wr_idx < 4'(NR)) m_mst[wr_idx] = wr_data;
      u3 = u2; u2 = u1; u1 = upd_in;
      t3 = t2; t2 = t1; t1 = tx_in;
    end
  end

  task automatic check(string req, logic [NR*16-1:0] got, logic [NR*16-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !rst) begin
      check(cur_req, slave_q, model_flat());
      check({cur_req, " int_tx"}, {{(NR*16-1){1'b0}}, int_tx_o}, {{(NR*16-1){1'b0}}, m_itx});
    end
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask

  task automatic do_reset();
    rst = 1; cyc(4); rst = 0;
  endtask

  initial begin
    #(CLK*200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog got=hung exp=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    @(negedge clk);
    do_reset();
    started = 1;
    // R1: reset values
    for (int i = 0; i < NR; i++) check("R1 reset value", slave_q[i*16 +: 16], RV);
    check("R1 int_tx low", {159'b0, int_tx_o}, '0);

    // R2: immediate copy lands exactly on the fourth edge
    cur_req = "R2";
    imm_mode = 1; upd_mask = '0;
    wr_en = 1; wr_idx = 3; wr_data = 16'h1234;
    @(negedge clk); wr_en = 0;
    cyc(3);
    check("R2 not before 4 clocks", slave_q[3*16 +: 16], RV);
    cyc(1);
    check("R2 at 4 clocks", slave_q[3*16 +: 16], 16'h1234);

    // R1: pending immediate cancelled by reset
    cur_req = "R1";
    wr_en = 1; wr_idx = 5; wr_data = 16'h5555;
    @(negedge clk); wr_en = 0;
    cyc(1); do_reset(); cyc(6);
    check("R1 pending dropped", slave_q[5*16 +: 16], RV);
    imm_mode = 0;

    // R3/R4: software strobe with partial mask
    cur_req = "R3";
    for (int i = 0; i < NR; i++) begin
      wr_en = 1; wr_idx = 4'(i); wr_data = 16'(16'h0100 + i); @(negedge clk);
    end
    wr_en = 0; upd_mask = 10'b0101010101;
    cur_req = "R4"; sw_upd = 1; @(negedge clk); sw_upd = 0; cyc(3);
    check("R3 masked-off reg 1 holds", slave_q[1*16 +: 16], RV);
    check("R4 reg 0 copied", slave_q[0 +: 16], 16'h0100);

    // R11: write and software copy on the same edge
    cur_req = "R11"; upd_mask = '1;
    sw_upd = 1; @(negedge clk); sw_upd = 0;
    wr_en = 1; wr_idx = 2; wr_data = 16'hBEEF; @(negedge clk); wr_en = 0;
    check("R11 old master taken", slave_q[2*16 +: 16], 16'h0102);

    // R5/R9: held update line gives one copy plus an internal pulse
    cur_req = "R5"; strobe_en = 1; hw_upd_en = 1; int_tx_en = 1; upd_sel = 2;
    upd_in[2] = 1; cyc(8); upd_in[2] = 0; cyc(3);
    cur_req = "R9"; int_tx_en = 1; sw_upd = 1; @(negedge clk); sw_upd = 0; cyc(4);

    // R6/R8: transmit line, unselected line ignored
    cur_req = "R8"; ext_tx_en = 1; tx_sel = 1;
    wr_en = 1; wr_idx = 7; wr_data = 16'h7777; @(negedge clk); wr_en = 0;
    tx_in[3] = 1; cyc(6); tx_in[3] = 0;
    check("R8 unselected line ignored", slave_q[7*16 +: 16], 16'h0107);
    cur_req = "R6"; tx_in[1] = 1; cyc(6); tx_in[1] = 0; cyc(2);
    check("R6 selected tx line copies", slave_q[7*16 +: 16], 16'h7777);

    // R7: master enable off
    cur_req = "R7"; strobe_en = 0;
    wr_en = 1; wr_idx = 8; wr_data = 16'h8888; @(negedge clk); wr_en = 0;
    upd_in = 4'hF; tx_in = 4'hF; cyc(6); upd_in = 0; tx_in = 0; cyc(4);
    check("R7 lines ignored when disabled", slave_q[8*16 +: 16], 16'h0108);

    // R10: out-of-range writes, then copy all
    cur_req = "R10";
    wr_en = 1; wr_idx = 12; wr_data = 16'hDEAD; @(negedge clk); wr_en = 0;
    sw_upd = 1; @(negedge clk); sw_upd = 0; cyc(3);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      case (n % 5)
        0: cur_req = "R3"; 1: cur_req = "R5"; 2: cur_req = "R9";
        3: cur_req = "R11"; default: cur_req = "R2";
      endcase
      wr_en     = ($urandom % 3) == 0;
      wr_idx    = 4'($urandom % 12);
      wr_data   = 16'($urandom);
      sw_upd    = ($urandom % 9) == 0;
      if ($urandom % 20 == 0) begin
        imm_mode = 1'($urandom); strobe_en = ($urandom % 4) != 0;
        hw_upd_en = 1'($urandom); ext_tx_en = 1'($urandom); int_tx_en = 1'($urandom);
        upd_sel = 2'($urandom); tx_sel = 2'($urandom); upd_mask = 10'($urandom);
      end
      if ($urandom % 4 == 0) upd_in = upd_in ^ 4'(1 << ($urandom % 4));
      if ($urandom % 4 == 0) tx_in  = tx_in  ^ 4'(1 << ($urandom % 4));
      if (n == 2000) begin rst = 1; cyc(3); rst = 0; end
      @(negedge clk);
    end
    wr_en = 0; sw_upd = 0; cyc(8);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule